// File: doc/BRIEF.md
# Serial TDM Stream Pseudo-Random Pattern Tester

The block tests one serial time-division-multiplexed stream. It holds a single pattern transmitter for the outgoing stream and a single pattern receiver for the incoming stream. Both follow one frame position counter. The counter advances on each bit strobe and realigns to bit 0 of channel 0 when a frame marker arrives. A slot carries test pattern only when two things hold: the host has marked its channel in a per-channel enable table, and the channel falls inside a window. The window is given by a start channel and a length, may wrap past the last channel of the frame, and covers from one channel up to the whole frame.

In enabled bit times the transmitter drives a maximal-length 15-stage pseudo-random sequence (x^15 + x^14 + 1) onto the outgoing stream and raises an insertion flag, so that the surrounding logic can substitute the pattern for normal traffic. In the same enabled bit times the receiver first captures 15 incoming bits to seed its own register. After that it predicts each further bit and counts every mismatch in a saturating counter. The host reads the counter and clears it through a simple address/data register port.

Top module: `ber_stream_tester`

## Requirements
- R1: When `frame_start_i` and `bit_en_i` are both high, that bit time is bit 0 of channel 0. Each `bit_en_i` advances the position by one bit, with `BITS_PER_CH` bits per channel and `NUM_CH` channels per frame, wrapping to channel 0 after the last bit. A `frame_start_i` without `bit_en_i` has no effect.
- R2: A bit time is enabled when `bit_en_i` is high, the table bit of its channel is 1, and (channel - start) mod `NUM_CH` <= the length register. The length register holds the channel count minus one, so its values 0..NUM_CH-1 give windows of 1..NUM_CH channels, and the window wraps past the last channel. `tx_ins_o` is high exactly in enabled bit times.
- R3: `tx_bit_o` is the top stage of a 15-bit shift register that reset fills with all ones. At each enabled bit time the register shifts toward the top, and (old top XOR old second stage) enters at the bottom. Outside enabled bit times `tx_bit_o` is 0 and the register holds its value.
- R4: After reset, the receiver loads the first 15 enabled received bits into its register and counts nothing while it does so.
- R5: After loading, each enabled received bit that differs from the predicted bit adds one to the error count, which is readable on the cycle after that bit time. Matching bits add nothing.
- R6: Received bits in bit times that are not enabled (window, table or `bit_en_i` low) are ignored and do not advance the receiver.
- R7: The error count saturates at 2^CNT_W-1 (65535 by default) and does not wrap.
- R8: Writing address 0x02 clears the error count to 0. A clear in the same cycle as a counted error leaves 0.
- R9: Register map: 0x00 window start channel (read/write), 0x01 window length minus one (read/write), 0x03 error count (read-only, and writes to it are ignored). Addresses 0x80+ch access the table bit of channel ch in data bit 0. Other addresses read 0. Reset values: start 0, length NUM_CH-1, table all 0, count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One serial bit time of the stream |
| frame_start_i | input | 1 | Marks bit 0 of channel 0 (with bit_en_i) |
| rx_bit_i | input | 1 | Incoming serial bit |
| tx_bit_o | output | 1 | Pattern bit for the outgoing stream |
| tx_ins_o | output | 1 | Pattern replaces traffic in this bit time |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | AW (8) | Host register address |
| host_wdata_i | input | DATA_W (16) | Host write data |
| host_rdata_o | output | DATA_W (16) | Host read data, combinational from address |

## Verification
`tx_ins_o` and `tx_bit_o` are combinational from registered state and the current strobes, so they are due in the same bit time the strobe is driven. The bench drives at the falling edge and compares 1 ns later against its own position, window and sequence model. An error or a clear takes effect at the next rising edge, and read data follows the address with no delay. Each count check therefore drives the address at the next falling edge, one cycle after the stimulus, and compares 1 ns later. Loading, wrap-around windows, bit strobe gaps, mid-frame realignment, clear/error collision and saturation each sit in their own directed task.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int unsigned PRBS_W     = 15;
  localparam int unsigned ADDR_START = 0;
  localparam int unsigned ADDR_LEN   = 1;
  localparam int unsigned ADDR_CLR   = 2;
  localparam int unsigned ADDR_CNT   = 3;

  // x^15 + x^14 + 1, shift toward MSB, feedback at LSB
  function automatic logic [PRBS_W-1:0] prbs_next(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
  endfunction
endpackage

// File: rtl/ber_frame_pos.sv
module ber_frame_pos #(
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned BITS_PER_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned BIT_W = $clog2(BITS_PER_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_en_i,
  input  logic            frame_start_i,
  output logic [CH_W-1:0] cur_ch_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_CH - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

  logic [BIT_W-1:0] bit_q, cur_bit;
  logic [CH_W-1:0]  ch_q, cur_ch;

  always_comb begin
    cur_bit = (frame_start_i && bit_en_i) ? '0 : bit_q;
    cur_ch  = (frame_start_i && bit_en_i) ? '0 : ch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      ch_q  <= '0;
    end else if (bit_en_i) begin
      if (cur_bit == BIT_LAST) begin
        bit_q <= '0;
        ch_q  <= (cur_ch == CH_LAST) ? '0 : cur_ch + 1'b1;
      end else begin
        bit_q <= cur_bit + 1'b1;
        ch_q  <= cur_ch;
      end
    end
  end

  assign cur_ch_o = cur_ch;

  AST_FRAME_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && bit_en_i) |=> (ch_q == '0 && bit_q == BIT_W'(1))); // R1
  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(ch_q) && $stable(bit_q))); // R1
endmodule

// File: rtl/ber_host_regs.sv
module ber_host_regs
  import ber_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CH_W-1:0]   cur_ch_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clr_o,
  output logic              ch_en_o
);
  logic [CH_W-1:0]   start_q, len_q, off;
  logic [NUM_CH-1:0] tbl_q;
  logic [AW-2:0]     tbl_off;
  logic [CH_W-1:0]   tidx;
  logic              tbl_sel, in_win;

  assign tbl_off = addr_i[AW-2:0];
  assign tidx    = CH_W'(tbl_off);
  assign tbl_sel = addr_i[AW-1] && (int'(tbl_off) < NUM_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      len_q   <= CH_W'(NUM_CH - 1);
      tbl_q   <= '0;
    end else if (we_i) begin
      if (tbl_sel)                        tbl_q[tidx] <= wdata_i[0];
      else if (addr_i == AW'(ADDR_START)) start_q <= wdata_i[CH_W-1:0];
      else if (addr_i == AW'(ADDR_LEN))   len_q   <= wdata_i[CH_W-1:0];
    end
  end

  // channel distance from window start, modulo NUM_CH
  always_comb begin
    if (cur_ch_i >= start_q) off = cur_ch_i - start_q;
    else                     off = CH_W'(NUM_CH + int'(cur_ch_i) - int'(start_q));
  end

  assign in_win  = (off <= len_q);
  assign ch_en_o = tbl_q[cur_ch_i] & in_win;
  assign clr_o   = we_i && (addr_i == AW'(ADDR_CLR));

  always_comb begin
    rdata_o = '0;
    if (addr_i[AW-1]) begin
      if (tbl_sel) rdata_o[0] = tbl_q[tidx];
    end else if (addr_i == AW'(ADDR_START)) rdata_o = DATA_W'(start_q);
    else if (addr_i == AW'(ADDR_LEN))       rdata_o = DATA_W'(len_q);
    else if (addr_i == AW'(ADDR_CNT))       rdata_o = DATA_W'(cnt_i);
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(tbl_q) && $stable(start_q) && $stable(len_q))); // R9
endmodule

// File: rtl/ber_prbs_gen.sv
module ber_prbs_gen
  import ber_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic bit_o
);
  logic [PRBS_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '1;
    else if (adv_i) state_q <= prbs_next(state_q);
  end

  assign bit_o = state_q[PRBS_W-1];

  AST_GEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R3
  AST_GEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q)); // R3
endmodule

// File: rtl/ber_prbs_chk.sv
module ber_prbs_chk
  import ber_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             rx_bit_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [3:0]       FILL_DONE = 4'(PRBS_W);

  logic [PRBS_W-1:0] state_q;
  logic [3:0]        fill_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              synced, pred, err;

  assign synced = (fill_q == FILL_DONE);
  assign pred   = state_q[PRBS_W-1] ^ state_q[PRBS_W-2];
  assign err    = sample_i && synced && (rx_bit_i != pred);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      fill_q  <= '0;
    end else if (sample_i) begin
      if (!synced) begin
        state_q <= {state_q[PRBS_W-2:0], rx_bit_i};
        fill_q  <= fill_q + 1'b1;
      end else begin
        // free-run on prediction so one flipped bit counts once
        state_q <= prbs_next(state_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (err && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R8
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX)); // R7
  AST_LOAD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!synced && !clr_i) |=> $stable(cnt_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> ($stable(state_q) && $stable(fill_q))); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R5
endmodule

// File: rtl/ber_stream_tester.sv
module ber_stream_tester #(
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned BITS_PER_CH = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned AW          = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              frame_start_i,
  input  logic              rx_bit_i,
  output logic              tx_bit_o,
  output logic              tx_ins_o,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0]  cur_ch;
  logic [CNT_W-1:0] err_cnt;
  logic             ch_en, slot_en, clr, gen_bit;

  ber_frame_pos #(.NUM_CH(NUM_CH), .BITS_PER_CH(BITS_PER_CH)) i_pos (
    .clk_i, .rst_ni, .bit_en_i, .frame_start_i, .cur_ch_o(cur_ch)
  );

  ber_host_regs #(.NUM_CH(NUM_CH), .AW(AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(host_we_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .cur_ch_i(cur_ch), .cnt_i(err_cnt),
    .rdata_o(host_rdata_o), .clr_o(clr), .ch_en_o(ch_en)
  );

  assign slot_en = bit_en_i & ch_en;

  ber_prbs_gen i_gen (.clk_i, .rst_ni, .adv_i(slot_en), .bit_o(gen_bit));

  ber_prbs_chk #(.CNT_W(CNT_W)) i_chk (
    .clk_i, .rst_ni, .sample_i(slot_en), .rx_bit_i, .clr_i(clr), .cnt_o(err_cnt)
  );

  assign tx_ins_o = slot_en;
  assign tx_bit_o = slot_en & gen_bit;

  AST_TX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |-> (!tx_ins_o && !tx_bit_o)); // R2
endmodule

// File: tb/test_ber_stream_tester.sv
module test_ber_stream_tester;
  localparam int NUM_CH = 32;
  localparam int BPC    = 8;
  localparam int FRAME  = NUM_CH * BPC;
  localparam int CNT_MAX = 65535;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, fs = 0, rx_bit = 0, we = 0;
  logic [7:0] addr = 0;
  logic [15:0] wdata = 0;
  logic tx_bit, tx_ins;
  logic [15:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  bit sh_tbl [NUM_CH];
  int sh_start = 0, sh_len = NUM_CH - 1;
  logic [14:0] ref_lfsr = '1;
  int ref_pos = 0, ref_fill = 0, ref_cnt = 0;
  bit garbage = 0;

  always #(CLK_NS/2) clk = ~clk;

  ber_stream_tester i_ber_stream_tester (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .frame_start_i(fs),
    .rx_bit_i(rx_bit), .tx_bit_o(tx_bit), .tx_ins_o(tx_ins),
    .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit ref_slot(input int pos);
    int ch, off;
    ch  = pos / BPC;
    off = (ch - sh_start + NUM_CH) % NUM_CH;
    return sh_tbl[ch] && (off <= sh_len);
  endfunction

  task automatic host_wr(input int a, input int d);
    @(negedge clk);
    bit_en = 0; fs = 0; we = 1; addr = 8'(a); wdata = 16'(d);
    if (a >= 128 && a < 128 + NUM_CH) sh_tbl[a-128] = d[0];
    else if (a == 0) sh_start = d % NUM_CH;
    else if (a == 1) sh_len = d % NUM_CH;
    else if (a == 2) ref_cnt = 0;
  endtask

  task automatic host_rd(input int a, output int d);
    @(negedge clk);
    bit_en = 0; fs = 0; we = 0; addr = 8'(a);
    #1 d = int'(rdata);
  endtask

  task automatic tick(input bit f, input bit en, input bit flip, input bit clr);
    int pos; bit ins, eb;
    @(negedge clk);
    pos = (f && en) ? 0 : ref_pos;
    ins = en && ref_slot(pos);
    eb  = ins ? ref_lfsr[14] : 1'b0;
    bit_en = en; fs = f; rx_bit = ins ? (eb ^ flip) : garbage;
    we = clr; addr = 8'd2; wdata = 0;
    #1;
    chk(tx_ins === ins, "R2 tx_ins", int'(tx_ins), int'(ins));
    chk(tx_bit === eb,  "R3 tx_bit", int'(tx_bit), int'(eb));
    if (clr) ref_cnt = 0;
    else if (ins && ref_fill >= 15 && flip && ref_cnt < CNT_MAX) ref_cnt++;
    if (ins) begin
      if (ref_fill < 15) ref_fill++;
      ref_lfsr = {ref_lfsr[13:0], ref_lfsr[14] ^ ref_lfsr[13]};
    end
    if (en) ref_pos = (pos + 1) % FRAME;
    garbage = ~garbage;
  endtask

  task automatic tick_to_slot();
    for (int i = 0; i < FRAME && !(ref_slot(ref_pos)); i++) tick(0, 1, 0, 0);
  endtask

  task automatic t_reset();
    int d;
    host_rd(0, d);   chk(d == 0, "R9 reset start", d, 0);
    host_rd(1, d);   chk(d == NUM_CH-1, "R9 reset len", d, NUM_CH-1);
    host_rd(3, d);   chk(d == 0, "R9 reset count", d, 0);
    host_rd(128, d); chk(d == 0, "R9 reset table", d, 0);
    for (int i = 0; i < 4; i++) tick(0, 1, 0, 0);
  endtask

  task automatic t_regs();
    int d;
    host_wr(0, 5);  host_rd(0, d); chk(d == 5, "R9 start rw", d, 5);
    host_wr(1, 3);  host_rd(1, d); chk(d == 3, "R9 len rw", d, 3);
    host_wr(135, 1); host_rd(135, d); chk(d == 1, "R9 table rw", d, 1);
    host_wr(3, 77); host_rd(3, d); chk(d == 0, "R9 count read-only", d, 0);
    host_rd(64, d); chk(d == 0, "R9 unmapped", d, 0);
    host_wr(135, 0);
  endtask

  // wrapping window 30,31,0,1 with channel 0 masked by the table
  task automatic t_tx_window();
    int d, n;
    for (int c = 0; c < NUM_CH; c++) host_wr(128 + c, (c == 0) ? 0 : 1);
    host_wr(0, NUM_CH - 2);
    host_wr(1, 3);
    n = 0;
    for (int i = 0; i < 2 * FRAME; i++) begin
      tick(i == 0, (i % 7) != 3, 0, 0);
      if (tx_ins) n++;
    end
    chk(n > 15, "R2 window slots seen", n, 16);
    host_rd(3, d); chk(d == 0, "R4 no count while loading/clean", d, 0);
  endtask

  task automatic t_errors();
    int d;
    for (int k = 1; k <= 3; k++) begin
      tick_to_slot();
      tick(0, 1, 1, 0);
      host_rd(3, d); chk(d == k, "R5 count after flip", d, k);
    end
    tick(0, 0, 1, 0);
    host_rd(3, d); chk(d == 3, "R6 bit_en low ignored", d, 3);
    for (int i = 0; i < FRAME; i++) tick(0, 1, 0, 0);
    host_rd(3, d); chk(d == 3 && d == ref_cnt, "R6 disabled slots ignored", d, 3);
  endtask

  task automatic t_clear_prio();
    int d;
    tick_to_slot();
    tick(0, 1, 1, 1);
    host_rd(3, d); chk(d == 0, "R8 clear beats error", d, 0);
    tick_to_slot();
    tick(0, 1, 1, 0);
    host_rd(3, d); chk(d == 1, "R5 count after clear", d, 1);
    host_wr(2, 0);
    host_rd(3, d); chk(d == 0, "R8 clear", d, 0);
  endtask

  task automatic t_realign();
    int n, first;
    for (int c = 0; c < NUM_CH; c++) host_wr(128 + c, (c == 3) ? 1 : 0);
    host_wr(0, 3); host_wr(1, 0);
    for (int i = 0; i < 13; i++) tick(0, 1, 0, 0);
    tick(1, 0, 0, 0);
    n = 0; first = -1;
    for (int i = 0; i < 40; i++) begin
      tick(i == 0, 1, 0, 0);
      if (tx_ins) begin n++; if (first < 0) first = i; end
    end
    chk(n == 8,      "R1 slots after realign", n, 8);
    chk(first == 24, "R1 first slot bit index", first, 24);
  endtask

  task automatic t_saturate();
    int d;
    for (int c = 0; c < NUM_CH; c++) host_wr(128 + c, 1);
    host_wr(0, 0); host_wr(1, NUM_CH - 1); host_wr(2, 0);
    for (int i = 0; i < CNT_MAX + 20; i++) tick(0, 1, 1, 0);
    host_rd(3, d); chk(d == CNT_MAX, "R7 saturate", d, CNT_MAX);
    host_wr(2, 0);
    host_rd(3, d); chk(d == 0, "R8 clear from max", d, 0);
  endtask

  initial begin
    #(CLK_NS * 180000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) sh_tbl[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_tx_window();
    t_errors();
    t_clear_prio();
    t_realign();
    t_saturate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule